// File: doc/BRIEF.md
# Sequential / Nested Interrupt Sequencer

This block sits between a set of interrupt request lines and a processor core. It collects the requests, decides which one the core should take next, and tracks which sources are being serviced. It raises a single interrupt line toward the core and presents the ID of the source to be taken. The core takes that source by pulsing an acknowledge. It reports that a handler has finished with an end-of-service pulse.

The block supports two service disciplines, chosen by a mode input. In sequential mode, interrupts are masked while any source is in service. Requests that arrive during that time are recorded and are handed out in the order they came in, once the service ends. In nested mode, the sources are ranked by index, with the highest index most urgent. A request that outranks every source in service preempts at once. Anything of equal or lower rank waits. Each end of service retires the most urgent active level, so control returns to the level that was preempted.

Top module: `irq_sequencer`

## Requirements
- R1: After synchronous reset, `irq_o` is low, and no source is pending or in service.
- R2: A source whose request line is high, and which is neither pending nor in service, becomes pending at that clock edge. It remains pending until it is acknowledged, even if its request line falls.
- R3: In sequential mode (`mode_i` = 0), `irq_o` is high only while no source is in service and at least one source is pending. Requests that arrive during a service keep `irq_o` low until that service ends.
- R4: In sequential mode, pending sources are offered on `irq_id_o` in the order their requests were latched. Sources latched on the same edge are offered lowest index first.
- R5: In nested mode (`mode_i` = 1), `irq_o` is high when the highest-index pending source is above the highest-index in-service source, or when nothing is in service. `irq_id_o` then names that pending source. This includes preempting a source that is already in service.
- R6: In nested mode, a pending source whose index is not above the highest in-service index gets no interrupt until that level finishes.
- R7: An `eos_i` pulse ends service of the highest-index source in service. The next most urgent in-service level becomes the active level again. A pending source is offered only if it outranks that level.
- R8: `ack_i` sampled while `irq_o` is high moves the offered source from pending to in service at that edge. `ack_i` while `irq_o` is low has no effect.
- R9: A source that is pending or in service is not latched again. After its service ends, a request line that is still high makes it pending again on the following edge.
- R10: `mode_i` may change only while nothing is pending or in service. The new discipline then applies from the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NSRC | Request line of each source |
| mode_i | input | 1 | 0 = sequential, 1 = nested |
| ack_i | input | 1 | Core takes the offered source |
| eos_i | input | 1 | Core finished the active handler |
| irq_o | output | 1 | Interrupt to the core |
| irq_id_o | output | $clog2(NSRC) | ID of the offered source |

## Verification
The assertions assume that the core changes `mode_i` only when the block is idle, and that `eos_i` is pulsed only when a handler is actually running. The in-service bookkeeping, including the single active source in sequential mode, rests on these two conditions. The stimulus respects both. Random phases drain the block before the mode flips. During a drain, request lines are held low and pending sources are acknowledged and ended until nothing remains. `eos_i` is generated only when the reference model has a source in service. Acknowledge pulses are also issued while `irq_o` is low, to exercise the case where they must be ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic {
    DISC_SEQ  = 1'b0,
    DISC_NEST = 1'b1
  } disc_e;
endpackage

// File: rtl/irqc_msb_find.sv
module irqc_msb_find #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_arrival_q.sv
module irqc_arrival_q #(
  parameter int N = 8,
  localparam int IDW = (N > 1) ? $clog2(N) : 1,
  localparam int CW  = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   push_vec_i,
  input  logic           pop_i,
  output logic [IDW-1:0] head_o,
  output logic           empty_o
);
  logic [IDW-1:0] mem [N];
  logic [IDW-1:0] wp_q, rp_q;
  logic [CW-1:0]  cnt_q;
  logic [N-1:0]   wr_en;
  logic [IDW-1:0] wr_id [N];
  int             n_push;

  // Same-cycle arrivals take consecutive slots, lowest index first (R4)
  always_comb begin
    int slot;
    wr_en  = '0;
    n_push = 0;
    slot   = 0;
    for (int k = 0; k < N; k++) wr_id[k] = '0;
    for (int i = 0; i < N; i++) begin
      if (push_vec_i[i]) begin
        slot = (int'(wp_q) + n_push) % N;
        wr_en[slot] = 1'b1;
        wr_id[slot] = IDW'(i);
        n_push = n_push + 1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < N; k++) begin
      if (wr_en[k]) mem[k] <= wr_id[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= IDW'((int'(wp_q) + n_push) % N);
      if (pop_i) rp_q <= IDW'((int'(rp_q) + 1) % N);
      cnt_q <= CW'(int'(cnt_q) + n_push - (pop_i ? 1 : 0));
    end
  end

  assign head_o  = mem[rp_q];
  assign empty_o = (cnt_q == '0);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= N);
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    pop_i |-> !empty_o);
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int NSRC = 8,
  localparam int IDW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] req_i,
  input  logic            mode_i,
  input  logic            ack_i,
  input  logic            eos_i,
  output logic            irq_o,
  output logic [IDW-1:0]  irq_id_o
);
  import irqc_pkg::*;

  disc_e           disc;
  logic [NSRC-1:0] pend_q, isr_q;
  logic [NSRC-1:0] fresh, take_mask, end_mask;
  logic            p_any, s_any, q_empty, take;
  logic [IDW-1:0]  p_idx, s_idx, q_head;
  logic            seq_ready, nest_ready;

  assign disc  = disc_e'(mode_i);
  // R9: only idle sources are latched
  assign fresh = req_i & ~pend_q & ~isr_q;

  irqc_msb_find #(.W(NSRC)) u_pend_top (.vec_i(pend_q), .any_o(p_any), .idx_o(p_idx));
  irqc_msb_find #(.W(NSRC)) u_isr_top  (.vec_i(isr_q),  .any_o(s_any), .idx_o(s_idx));

  irqc_arrival_q #(.N(NSRC)) u_order (
    .clk        (clk),
    .rst        (rst),
    .push_vec_i ((disc == DISC_SEQ) ? fresh : '0),
    .pop_i      (take && (disc == DISC_SEQ)),
    .head_o     (q_head),
    .empty_o    (q_empty)
  );

  // R3: masked while anything is in service; R5/R6: strict rank compare
  assign seq_ready  = !s_any && !q_empty;
  assign nest_ready = p_any && (!s_any || (p_idx > s_idx));

  assign irq_o    = (disc == DISC_NEST) ? nest_ready : seq_ready;
  assign irq_id_o = (disc == DISC_NEST) ? p_idx : q_head;

  // R8 / R7
  assign take      = ack_i && irq_o;
  assign take_mask = take ? (NSRC'(1) << irq_id_o) : '0;
  assign end_mask  = (eos_i && s_any) ? (NSRC'(1) << s_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~take_mask) | fresh;
      isr_q  <= (isr_q & ~end_mask) | take_mask;
    end
  end

  a_r2_pending_kept: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(pend_q) & ~$past(take_mask) & ~pend_q) == '0));
  a_r3_one_in_service: assert property (@(posedge clk) disable iff (rst)
    (disc == DISC_SEQ) |-> ($countones(isr_q) <= 1));
  a_r8_ack_moves: assert property (@(posedge clk) disable iff (rst)
    take |=> (isr_q[$past(irq_id_o)] && !pend_q[$past(irq_id_o)]));
  a_r7_eos_retires_one: assert property (@(posedge clk) disable iff (rst)
    (eos_i && s_any && !take) |=> ($countones(isr_q) == $past($countones(isr_q)) - 1));
  a_r9_disjoint: assert property (@(posedge clk) disable iff (rst)
    (pend_q & isr_q) == '0);
  a_r10_mode_idle: assert property (@(posedge clk) disable iff (rst)
    (mode_i != $past(mode_i)) |-> (pend_q == '0 && isr_q == '0));
endmodule

// File: tb/irq_sequencer_test.sv
module irq_sequencer_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_i = '0;
  logic         mode_i = 1'b0;
  logic         ack_i = 1'b0;
  logic         eos_i = 1'b0;
  logic         irq_o;
  logic [2:0]   irq_id_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [N-1:0] m_pend, m_isr;
  int           mq [N];
  int           mqn;

  irq_sequencer #(.NSRC(N)) uut (
    .clk(clk), .rst(rst), .req_i(req_i), .mode_i(mode_i),
    .ack_i(ack_i), .eos_i(eos_i), .irq_o(irq_o), .irq_id_o(irq_id_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected at most 200000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int top_of(logic [N-1:0] v);
    int r = -1;
    for (int i = 0; i < N; i++) if (v[i]) r = i;
    return r;
  endfunction

  function automatic logic exp_irq();
    if (mode_i) return (m_pend != '0) && (top_of(m_pend) > top_of(m_isr));
    return (m_isr == '0) && (mqn > 0);
  endfunction

  function automatic int exp_id();
    if (mode_i) return top_of(m_pend);
    return mq[0];
  endfunction

  task automatic cmp(input string tag);
    logic ei;
    int   eid;
    ei  = exp_irq();
    eid = exp_id();
    checks++;
    if (irq_o !== ei || (ei && int'(irq_id_o) != eid)) begin
      fails++;
      $display("FAIL %s: actual irq=%0b id=%0d, expected irq=%0b id=%0d",
               tag, irq_o, irq_id_o, ei, eid);
    end
  endtask

  task automatic expect_out(input logic ei, input int eid, input string tag);
    checks++;
    if (irq_o !== ei || (ei && int'(irq_id_o) != eid)) begin
      fails++;
      $display("FAIL %s: actual irq=%0b id=%0d, expected irq=%0b id=%0d",
               tag, irq_o, irq_id_o, ei, eid);
    end
  endtask

  // Called at a negedge: check, drive, advance model, wait next negedge
  task automatic step(input logic [N-1:0] r, input logic a, input logic e, input string tag);
    logic         ei;
    int           eid, hi;
    logic [N-1:0] tk, en, nv;
    cmp(tag);
    req_i = r; ack_i = a; eos_i = e;
    ei = exp_irq(); eid = exp_id();
    tk = (a && ei) ? (N'(1) << eid) : '0;
    hi = top_of(m_isr);
    en = (e && hi >= 0) ? (N'(1) << hi) : '0;
    nv = r & ~m_pend & ~m_isr;
    if (!mode_i) begin
      if (a && ei) begin
        for (int k = 0; k < N - 1; k++) mq[k] = mq[k+1];
        mqn--;
      end
      for (int i = 0; i < N; i++) if (nv[i]) begin mq[mqn] = i; mqn++; end
    end
    m_pend = (m_pend & ~tk) | nv;
    m_isr  = (m_isr & ~en) | tk;
    @(negedge clk);
  endtask

  task automatic drain(input string tag);
    for (int g = 0; g < 200 && (m_pend != '0 || m_isr != '0); g++)
      step('0, exp_irq(), (m_isr != '0) && !exp_irq(), tag);
  endtask

  initial begin
    logic [N-1:0] r;
    logic         a, e;
    void'($urandom(32'd20240611));
    m_pend = '0; m_isr = '0; mqn = 0;
    for (int k = 0; k < N; k++) mq[k] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    expect_out(1'b0, 0, "R1");

    // Sequential discipline
    step(8'h04, 0, 0, "R2");  expect_out(1, 2, "R2");
    step(8'h00, 1, 0, "R8");  expect_out(0, 0, "R8");
    step(8'hA0, 0, 0, "R3");  expect_out(0, 0, "R3");
    step(8'h02, 0, 0, "R3");  expect_out(0, 0, "R3");
    step(8'h00, 0, 1, "R4");  expect_out(1, 5, "R4");
    step(8'h00, 1, 0, "R4");  step(8'h00, 0, 1, "R4"); expect_out(1, 7, "R4");
    step(8'h00, 1, 0, "R4");  step(8'h00, 0, 1, "R4"); expect_out(1, 1, "R4");
    step(8'h00, 1, 0, "R4");  step(8'h00, 0, 1, "R4"); expect_out(0, 0, "R4");
    step(8'h00, 1, 0, "R8");  expect_out(0, 0, "R8");
    step(8'h08, 0, 0, "R8");  expect_out(1, 3, "R8");
    step(8'h00, 1, 0, "R8");  step(8'h00, 0, 1, "R8");

    // Nested discipline
    mode_i = 1'b1;
    step(8'h08, 0, 0, "R10"); expect_out(1, 3, "R10");
    step(8'h00, 1, 0, "R5");  expect_out(0, 0, "R5");
    step(8'h02, 0, 0, "R6");  expect_out(0, 0, "R6");
    step(8'h08, 0, 0, "R9");  expect_out(0, 0, "R9");
    step(8'h40, 0, 0, "R5");  expect_out(1, 6, "R5");
    step(8'h00, 1, 0, "R5");  expect_out(0, 0, "R6");
    step(8'h40, 0, 0, "R6");  expect_out(0, 0, "R6");
    step(8'h00, 0, 1, "R7");  expect_out(0, 0, "R7");
    step(8'h00, 0, 1, "R7");  expect_out(1, 1, "R7");
    step(8'h00, 1, 0, "R9");
    step(8'h02, 0, 1, "R9");  expect_out(0, 0, "R9");
    step(8'h02, 0, 0, "R9");  expect_out(1, 1, "R9");
    step(8'h00, 1, 0, "R9");  step(8'h00, 0, 1, "R9");
    drain("R10");

    // Random phases, drained before each mode flip
    for (int ph = 0; ph < 12; ph++) begin
      for (int c = 0; c < 300; c++) begin
        r = N'($urandom & $urandom & $urandom);
        a = exp_irq() ? ($urandom % 3 == 0) : ($urandom % 8 == 0);
        e = (m_isr != '0) && ($urandom % 4 == 0);
        step(r, a, e, mode_i ? "R5" : "R4");
      end
      drain("R10");
      step('0, 0, 0, "R10");
      mode_i = ~mode_i;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule